// File: doc/BRIEF.md
# Boundary-Scan Test Port with AC Extest Modes

This block is a boundary-scan test access port controller. A tester drives it serially through a clock, a mode select, a data input and an active-low test reset, and reads back a data output. A 4-bit instruction selects which serial register sits between data in and data out. The choices are a one-bit bypass stage, a fixed 32-bit identification word, a user data register, or a boundary register. The boundary register has one cell per pad and its length is a parameter.

The instruction also decides what reaches the pads. The pads either follow the core's own values, or take a scanned test value, or are switched off. A few of the lowest cells stand for AC-coupled differential outputs. In the two AC test instructions these cells can drive the opposite of their scanned value, so a receiver at the far end of a coupling capacitor sees an edge. One mode gives a single inversion, the other a continuous toggle. Each pad cell captures only the level seen at the pad. The core's own value is never captured. There is no internal-test instruction.

All state is clocked by the test clock. The test reset is sampled on the rising edge. The serial output and its enable change on the falling edge.

Top module: `bscan_tap`

## Requirements
- R1: The controller follows the standard 16-state test port machine. A low test reset at a rising clock edge, or five consecutive rising edges with mode select high, puts it in Test-Logic-Reset. Test-Logic-Reset makes IDCODE (4'b0110) the active instruction, or BYPASS when HAS_ID is 0.
- R2: The instruction register is 4 bits wide and shifts least significant bit first. In Capture-IR it loads 4'b0001, so the first four output bits of an instruction scan read 1,0,0,0.
- R3: IDCODE (4'b0110) selects a 32-bit register. It captures {VERSION, 28'h0006351} and shifts it out bit 0 first.
- R4: BYPASS is selected by 4'b0000 and 4'b1111. Every code not named in R2 to R11 (0100, 0101, 0111, 1010, 1101, 1110) also acts as BYPASS. BYPASS is a one-bit stage that captures 0, and while it is active the pads follow core_out. The all-zero code never drives test values onto the pads.
- R5: SAMPLE/PRELOAD (4'b0001) selects the boundary register, BSR_LEN bits long. Bit i captures pad_in[i], and bit 0 is shifted out first. Update-DR copies the shifted bits into the update stage. The pads keep following core_out.
- R6: EXTEST (4'b1000) drives the update stage onto pad_out. The value is static: it stays the same in every TAP state until the next Update-DR.
- R7: EXTEST_PULSE (4'b1011) drives the update stage onto the pads. Cells 0 to AC_CNT-1 drive the inverted value from the first falling edge in Run-Test/Idle until the first falling edge after leaving that state. The other cells stay static.
- R8: EXTEST_TRAIN (4'b1100) drives the update stage onto the pads. Cells 0 to AC_CNT-1 invert on every falling edge while the controller is in Run-Test/Idle, and the first inversion comes at the first such edge. Outside that state they drive the update value.
- R9: CLAMP (4'b0011) drives the update stage onto the pads and selects the one-bit bypass stage.
- R10: HIGHZ (4'b0010) drives pad_oe all low and selects the bypass stage. Under every other instruction pad_oe is all high.
- R11: USER (4'b1001) selects a UDR_W-bit user register. It captures its held value, Update-DR loads it with the shifted bits, and it resets to 0.
- R12: tdo and tdo_oe change only on the falling edge of tck. tdo_oe is high only in Shift-DR and Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on the rising edge |
| tms | input | 1 | Mode select that steers the state machine |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for tdo, high while shifting |
| core_out | input | BSR_LEN | Values the core would drive on the pads |
| pad_in | input | BSR_LEN | Levels observed at the pads |
| pad_out | output | BSR_LEN | Values driven to the pads |
| pad_oe | output | BSR_LEN | Pad output enables |

## Verification
The bench goes after the all-zero opcode and the six unlisted codes. A decoder that treated any of these as a test instruction would show a register longer than one bit, or would drive scanned values onto the pads. It times tdo against both clock edges. An output stage clocked on the rising edge would change its value one half cycle early. The AC modes are sampled on consecutive falling edges in Run-Test/Idle and again after leaving that state. This exposes a pulse that keeps toggling, a train that holds still, an inversion that leaks onto non-AC cells, and an inversion that stays after the state is left. It also walks the controller back to reset with five high mode-select cycles from an arbitrary instruction and expects the identification word to come back.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 4;
  localparam int ID_W = 32;
  localparam logic [27:0] ID_BODY = 28'h0006351;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0010;
  localparam logic [IR_W-1:0] OP_CLAMP   = 4'b0011;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0110;
  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b1000;
  localparam logic [IR_W-1:0] OP_USER    = 4'b1001;
  localparam logic [IR_W-1:0] OP_XPULSE  = 4'b1011;
  localparam logic [IR_W-1:0] OP_XTRAIN  = 4'b1100;

  typedef enum logic [1:0] { DR_BYP, DR_ID, DR_BSR, DR_USR } dr_sel_e;

  typedef struct packed {
    dr_sel_e dr;
    logic    drive_test;
    logic    pins_hiz;
    logic    ac_pulse;
    logic    ac_train;
  } ir_dec_t;

  // Unlisted codes fall through to the bypass default.
  function automatic ir_dec_t decode_op(logic [IR_W-1:0] op, logic has_id);
    ir_dec_t d;
    d = '{dr: DR_BYP, drive_test: 1'b0, pins_hiz: 1'b0, ac_pulse: 1'b0, ac_train: 1'b0};
    case (op)
      OP_SAMPLE: d.dr = DR_BSR;
      OP_HIGHZ:  d.pins_hiz = 1'b1;
      OP_CLAMP:  d.drive_test = 1'b1;
      OP_IDCODE: d.dr = has_id ? DR_ID : DR_BYP;
      OP_EXTEST: begin d.dr = DR_BSR; d.drive_test = 1'b1; end
      OP_USER:   d.dr = DR_USR;
      OP_XPULSE: begin d.dr = DR_BSR; d.drive_test = 1'b1; d.ac_pulse = 1'b1; end
      OP_XTRAIN: begin d.dr = DR_BSR; d.drive_test = 1'b1; d.ac_train = 1'b1; end
      default:   d.dr = DR_BYP;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_TLR;
    else     state <= nxt;
  end

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
#(
  parameter logic [IR_W-1:0] RESET_OP = OP_IDCODE
)(
  input  logic            tck,
  input  logic            rst,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic [IR_W-1:0] ir_sh,
  output logic            sout
);

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sh <= IR_CAPTURE;
      ir_q  <= RESET_OP;
    end else begin
      case (state)
        ST_TLR:    ir_q  <= RESET_OP;
        ST_CAP_IR: ir_sh <= IR_CAPTURE;
        ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        ST_UPD_IR: ir_q  <= ir_sh;
        default: ;
      endcase
    end
  end

  assign sout = ir_sh[0];

endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr
  import bscan_pkg::*;
#(
  parameter int N      = 8,
  parameter int AC_CNT = 4
)(
  input  logic         tck,
  input  logic         rst,
  input  tap_state_e   state,
  input  logic         sel,
  input  logic         drive_test,
  input  logic         pins_hiz,
  input  logic         ac_inv,
  input  logic         tdi,
  input  logic [N-1:0] pad_in,
  input  logic [N-1:0] core_out,
  output logic         sout,
  output logic [N-1:0] upd,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);

  logic [N-1:0] sh;

  // Capture takes only the pad level; the core value never enters the chain.
  always_ff @(posedge tck) begin
    if (rst) begin
      sh  <= '0;
      upd <= '0;
    end else if (sel) begin
      case (state)
        ST_CAP_DR: sh  <= pad_in;
        ST_SH_DR:  sh  <= {tdi, sh[N-1:1]};
        ST_UPD_DR: upd <= sh;
        default: ;
      endcase
    end
  end

  assign sout = sh[0];

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam bit IS_AC = (i < AC_CNT);
    logic flip;
    assign flip       = IS_AC & ac_inv;
    assign pad_out[i] = drive_test ? (upd[i] ^ flip) : core_out[i];
    assign pad_oe[i]  = ~pins_hiz;
  end

endmodule

// File: rtl/bscan_acdrv.sv
module bscan_acdrv
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  tap_state_e state,
  input  logic       ac_pulse,
  input  logic       ac_train,
  output logic       ac_inv
);

  logic in_idle;
  assign in_idle = (state == ST_RTI);

  always_ff @(negedge tck) begin
    if (rst)                     ac_inv <= 1'b0;
    else if (in_idle && ac_train) ac_inv <= ~ac_inv;
    else if (in_idle && ac_pulse) ac_inv <= 1'b1;
    else                          ac_inv <= 1'b0;
  end

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int              BSR_LEN = 8,
  parameter int              AC_CNT  = 4,
  parameter int              UDR_W   = 8,
  parameter logic [3:0]      VERSION = 4'h3,
  parameter bit              HAS_ID  = 1'b1
)(
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] core_out,
  input  logic [BSR_LEN-1:0] pad_in,
  output logic [BSR_LEN-1:0] pad_out,
  output logic [BSR_LEN-1:0] pad_oe
);

  localparam logic [IR_W-1:0] RESET_OP = HAS_ID ? OP_IDCODE : OP_BYPASS;
  localparam logic [ID_W-1:0] ID_WORD  = {VERSION, ID_BODY};

  logic             rst;
  tap_state_e       state;
  logic [IR_W-1:0]  ir_q;
  logic [IR_W-1:0]  ir_sh;
  logic             ir_sout;
  ir_dec_t          dec;
  logic             byp;
  logic [ID_W-1:0]  id_sh;
  logic [UDR_W-1:0] udr_sh;
  logic [UDR_W-1:0] udr_q;
  logic             bsr_sout;
  logic [BSR_LEN-1:0] bsr_upd;
  logic             ac_inv;
  logic             dr_sout;
  logic             tdo_d;
  logic             shifting;

  assign rst = ~trst_n;
  assign dec = decode_op(ir_q, HAS_ID);

  bscan_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  bscan_ir #(.RESET_OP(RESET_OP)) u_ir (
    .tck   (tck),
    .rst   (rst),
    .state (state),
    .tdi   (tdi),
    .ir_q  (ir_q),
    .ir_sh (ir_sh),
    .sout  (ir_sout)
  );

  bscan_bsr #(.N(BSR_LEN), .AC_CNT(AC_CNT)) u_bsr (
    .tck        (tck),
    .rst        (rst),
    .state      (state),
    .sel        (dec.dr == DR_BSR),
    .drive_test (dec.drive_test),
    .pins_hiz   (dec.pins_hiz),
    .ac_inv     (ac_inv),
    .tdi        (tdi),
    .pad_in     (pad_in),
    .core_out   (core_out),
    .sout       (bsr_sout),
    .upd        (bsr_upd),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
  );

  bscan_acdrv u_ac (
    .tck      (tck),
    .rst      (rst),
    .state    (state),
    .ac_pulse (dec.ac_pulse),
    .ac_train (dec.ac_train),
    .ac_inv   (ac_inv)
  );

  // Small data registers: bypass stage, identification, user register.
  always_ff @(posedge tck) begin
    if (rst) begin
      byp    <= 1'b0;
      id_sh  <= '0;
      udr_sh <= '0;
      udr_q  <= '0;
    end else begin
      case (dec.dr)
        DR_BYP: begin
          if (state == ST_CAP_DR)     byp <= 1'b0;
          else if (state == ST_SH_DR) byp <= tdi;
        end
        DR_ID: begin
          if (state == ST_CAP_DR)     id_sh <= ID_WORD;
          else if (state == ST_SH_DR) id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
        DR_USR: begin
          if (state == ST_CAP_DR)      udr_sh <= udr_q;
          else if (state == ST_SH_DR)  udr_sh <= {tdi, udr_sh[UDR_W-1:1]};
          else if (state == ST_UPD_DR) udr_q  <= udr_sh;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (dec.dr)
      DR_ID:   dr_sout = id_sh[0];
      DR_BSR:  dr_sout = bsr_sout;
      DR_USR:  dr_sout = udr_sh[0];
      default: dr_sout = byp;
    endcase
  end

  assign shifting = (state == ST_SH_DR) || (state == ST_SH_IR);
  assign tdo_d    = (state == ST_SH_IR) ? ir_sout : dr_sout;

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= shifting ? tdo_d : 1'b0;
      tdo_oe <= shifting;
    end
  end

endmodule

// File: rtl/bscan_tap_chk.sv
module bscan_tap_chk
  import bscan_pkg::*;
#(
  parameter int N = 8
)(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input logic            tdo_oe,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_q,
  input logic [IR_W-1:0] ir_sh,
  input logic [N-1:0]    pad_out,
  input logic [N-1:0]    pad_oe,
  input logic [N-1:0]    core_out,
  input logic [N-1:0]    bsr_upd
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck) begin
    if (!trst_n)  ones_cnt <= '0;
    else if (tms) ones_cnt <= (ones_cnt == 3'd5) ? 3'd5 : ones_cnt + 3'd1;
    else          ones_cnt <= '0;
  end

  // R1
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (state == ST_TLR));

  // R2
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sh == 4'b0001));

  // R4
  zero_op_no_drive_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_q == 4'b0000) |-> (pad_out == core_out));

  // R6
  extest_static_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_q == 4'b1000) |-> (pad_out == bsr_upd));

  // R10
  highz_oe_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_q == 4'b0010) |-> (pad_oe == '0));

  // R12
  tdo_oe_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> ((state == ST_SH_DR) || (state == ST_SH_IR)));

endmodule

bind bscan_tap bscan_tap_chk #(.N(BSR_LEN)) u_chk (
  .tck      (tck),
  .trst_n   (trst_n),
  .tms      (tms),
  .tdo_oe   (tdo_oe),
  .state    (state),
  .ir_q     (ir_q),
  .ir_sh    (ir_sh),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .core_out (core_out),
  .bsr_upd  (bsr_upd)
);

// File: tb/bscan_tap_bench.sv
`timescale 1ns/1ps
module bscan_tap_bench;

  localparam int         BSR_LEN = 8;
  localparam int         AC_CNT  = 4;
  localparam int         UDR_W   = 8;
  localparam logic [3:0] VERSION = 4'h3;
  localparam int         NSH     = 40;
  localparam logic [BSR_LEN-1:0] AC_MASK = (BSR_LEN'(1) << AC_CNT) - BSR_LEN'(1);
  localparam logic [63:0] ID_EXP = {32'h0, VERSION, 28'h0006351};

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe;
  logic [BSR_LEN-1:0] core_v = '0;
  logic [BSR_LEN-1:0] pin_v = '0;
  logic [BSR_LEN-1:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  logic last_oe;

  logic [3:0]         m_ir;
  logic [BSR_LEN-1:0] m_upd;
  logic [UDR_W-1:0]   m_udr;

  always #2.5 tck = ~tck;

  bscan_tap #(.BSR_LEN(BSR_LEN), .AC_CNT(AC_CNT), .UDR_W(UDR_W), .VERSION(VERSION), .HAS_ID(1'b1)) u_bscan_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .core_out(core_v), .pad_in(pin_v), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_bsr(logic [3:0] op);
    return op == 4'b0001 || op == 4'b1000 || op == 4'b1011 || op == 4'b1100;
  endfunction

  function automatic bit drives(logic [3:0] op);
    return op == 4'b1000 || op == 4'b1011 || op == 4'b1100 || op == 4'b0011;
  endfunction

  function automatic int op_len(logic [3:0] op);
    if (is_bsr(op))    return BSR_LEN;
    if (op == 4'b0110) return 32;
    if (op == 4'b1001) return UDR_W;
    return 1;
  endfunction

  function automatic logic [63:0] op_cap(logic [3:0] op);
    if (is_bsr(op))    return 64'(pin_v);
    if (op == 4'b0110) return ID_EXP;
    if (op == 4'b1001) return 64'(m_udr);
    return 64'h0;
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'b0110: return "R3";
      4'b0001: return "R5";
      4'b1000: return "R6";
      4'b1011: return "R7";
      4'b1100: return "R8";
      4'b0011: return "R9";
      4'b0010: return "R10";
      4'b1001: return "R11";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [63:0] exp_shift(logic [3:0] op, logic [63:0] t);
    logic [63:0] c, r;
    int l;
    l = op_len(op);
    c = op_cap(op);
    r = '0;
    for (int i = 0; i < NSH; i++) r[i] = (i < l) ? c[i] : t[i-l];
    return r;
  endfunction

  function automatic logic [BSR_LEN-1:0] exp_pad(logic [3:0] op, logic inv);
    if (!drives(op)) return core_v;
    if (inv && (op == 4'b1011 || op == 4'b1100)) return m_upd ^ AC_MASK;
    return m_upd;
  endfunction

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo;
    last_oe = tdo_oe;
    tms = m;
    tdi = d;
  endtask

  task automatic load_ir(input logic [3:0] op);
    logic o;
    logic [3:0] cap;
    logic all_oe;
    all_oe = 1'b1;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], o);
      cap[i] = o;
      all_oe &= last_oe;
    end
    step(1, 0, o); step(0, 0, o);
    m_ir = op;
    chk("R2", 64'(cap), 64'h1);
    chk("R12", 64'(all_oe), 64'h1);
  endtask

  task automatic scan_dr(input logic [63:0] t, output logic [63:0] got);
    logic o;
    int l;
    got = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < NSH; i++) begin
      step(i == NSH-1, t[i], o);
      got[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
    l = op_len(m_ir);
    if (is_bsr(m_ir))    m_upd = BSR_LEN'(t >> (NSH - l));
    if (m_ir == 4'b1001) m_udr = UDR_W'(t >> (NSH - l));
  endtask

  task automatic scan_check(input logic [63:0] t);
    logic [63:0] exp, got;
    exp = exp_shift(m_ir, t);
    scan_dr(t, got);
    chk(req_of(m_ir), got, exp);
  endtask

  task automatic tms_reset();
    logic o;
    for (int i = 0; i < 5; i++) step(1, 0, o);
    step(0, 0, o);
    m_ir = 4'b0110;
  endtask

  task automatic idle_sample();
    @(negedge tck); #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge tck);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic o;
    logic [63:0] t;
    logic [3:0] op;
    void'($urandom(32'h5EED_1234));
    m_ir = 4'b0110; m_upd = '0; m_udr = '0;
    core_v = 8'hA5;
    pin_v  = 8'h3C;
    repeat (4) @(posedge tck);
    idle_sample();
    chk("R12", 64'(tdo_oe), 64'h0);
    chk("R10", 64'(pad_oe), 64'(8'hFF));
    chk("R1", 64'(pad_out), 64'(core_v));
    trst_n = 1'b1;
    tms = 1'b0;
    repeat (2) @(posedge tck);

    // R1 R3: identification word after reset
    scan_check(64'hDEAD_BEEF_1234);
    // R11: user register resets to zero, then holds written value
    load_ir(4'b1001);
    scan_check(64'h00F0_0000_5A00);
    scan_check(64'h0);

    // R4 R12: tdo moves only on the falling edge
    load_ir(4'b0000);
    step(1, 0, o); step(0, 0, o); step(0, 1, o); step(0, 1, o);
    chk("R4", 64'(o), 64'h0);
    @(posedge tck); #1;
    chk("R12", 64'(tdo), 64'h0);
    @(negedge tck); #1;
    chk("R12", 64'(tdo), 64'h1);
    tms = 1'b1; tdi = 1'b0;
    step(1, 0, o); step(0, 0, o);
    idle_sample();
    chk("R12", 64'(tdo_oe), 64'h0);

    // R5 then R6: preload, then static drive
    load_ir(4'b0001);
    scan_check(64'h00AB_CDEF_0000_9600);
    idle_sample();
    chk("R5", 64'(pad_out), 64'(core_v));
    load_ir(4'b1000);
    for (int k = 0; k < 5; k++) begin
      core_v = 8'(k * 37);
      idle_sample();
      chk("R6", 64'(pad_out), 64'(m_upd));
    end

    // R7: single inversion held in idle, released after leaving
    load_ir(4'b1011);
    for (int k = 0; k < 3; k++) begin
      idle_sample();
      chk("R7", 64'(pad_out), 64'(m_upd ^ AC_MASK));
    end
    step(1, 0, o);
    idle_sample();
    chk("R7", 64'(pad_out), 64'(m_upd));
    tms = 1'b0;
    step(1, 0, o); step(1, 0, o); step(0, 0, o);
    m_upd = pin_v;

    // R8: toggle on every falling edge in idle
    load_ir(4'b1100);
    for (int k = 0; k < 4; k++) begin
      idle_sample();
      chk("R8", 64'(pad_out), 64'(m_upd ^ ((k % 2 == 0) ? AC_MASK : '0)));
    end

    // R1: five high mode-select cycles restore the identification word
    tms_reset();
    scan_check(64'h1);

    // Unlisted codes and the upper bypass code, R4
    foreach (op_list[i]) begin
      load_ir(op_list[i]);
      scan_check(64'h00C3_5A5A_F00F);
      idle_sample();
      chk("R4", 64'(pad_out), 64'(core_v));
    end

    // Random mix
    for (int it = 0; it < 60; it++) begin
      core_v = 8'($urandom);
      pin_v  = 8'($urandom);
      if ($urandom % 8 == 0) tms_reset();
      else begin
        op = 4'($urandom);
        load_ir(op);
      end
      t = {$urandom, $urandom};
      scan_check(t);
      idle_sample();
      chk(req_of(m_ir), 64'(pad_out), 64'(exp_pad(m_ir, 1'b1)));
      chk((m_ir == 4'b0010) ? "R10" : "R10", 64'(pad_oe),
          (m_ir == 4'b0010) ? 64'h0 : 64'(8'hFF));
      if (m_ir == 4'b1100) begin
        idle_sample();
        chk("R8", 64'(pad_out), 64'(exp_pad(m_ir, 1'b0)));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [3:0] op_list [7] = '{4'b0100, 4'b0101, 4'b0111, 4'b1010, 4'b1101, 4'b1110, 4'b1111};

endmodule